// File: doc/BRIEF.md
# Transmit PTP timestamp capture unit

This unit sits beside the transmit datapath of an Ethernet MAC. It watches the handshake of the AXI4-Stream frame interface that feeds the MAC. It also watches a free-running PTP time value that lives in the same clock domain. When the first beat of a frame is accepted, it captures the current time together with a tag that the frame's source placed in the upper tuser bits. The time and tag are stored as one record in a small in-order queue.

Records leave the queue on a separate result port. Each result appears as a timestamp word and a tag word, qualified by a valid strobe that is high for one clock. A parameterised gap models a downstream consumer that can only take a result every few clocks, so a burst of short frames builds up in the queue instead of being lost. If a frame starts while the queue is full, its record is dropped and a sticky overflow flag is raised.

Top module: `ptp_tx_stamp`

## Requirements
- R1: After a synchronous active-high reset, `res_stamp`, `res_tag`, `res_valid` and `stamp_overflow` are all zero.
- R2: A record is captured only on a beat with `fr_valid` and `fr_ready` both high while no frame is open. The record's stamp equals `ptp_now` as seen at that same clock edge.
- R3: The captured tag is `fr_user[16:1]` of the first beat, which is tuser shifted right by one. Bit 0, the error mark, has no effect on any output.
- R4: Beats after the first one of a frame never capture. A frame stays open until a beat with `fr_last` is accepted. Beats without the full handshake neither capture nor change the open/closed state.
- R5: Results come out in the order in which the frames started. The queue holds at most `DEPTH` records.
- R6: `res_valid` is high for exactly one clock per reported record. After each report, at least `OUT_GAP` clocks with `res_valid` low follow.
- R7: `res_valid` is low on every clock in which no record is pending for release.
- R8: A frame start that finds the queue full is discarded, unless a record is released on the same clock. A discarded start sets `stamp_overflow`, which then stays high until reset.
- R9: With `TIME_EN` = 0, `res_stamp` stays zero. Tags and valid strobes behave exactly as with `TIME_EN` = 1.
- R10: A capture that finds the queue empty and the pacer idle is reported with `res_valid` high in the clock right after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the stream and the time value |
| rst | input | 1 | Synchronous active-high reset |
| fr_valid | input | 1 | Stream tvalid being observed |
| fr_ready | input | 1 | Stream tready being observed |
| fr_last | input | 1 | Stream tlast being observed |
| fr_user | input | 17 | Stream tuser; bit 0 error mark, bits 16:1 tag |
| ptp_now | input | 96 | Free-running PTP time |
| res_stamp | output | 96 | Reported timestamp |
| res_tag | output | 16 | Reported tag |
| res_valid | output | 1 | One-clock strobe qualifying a result |
| stamp_overflow | output | 1 | Sticky flag: a frame start was discarded |

## Verification
The hardest case to reach is a frame start that arrives exactly when the queue is full. On that clock the pacer may or may not release a record at the same edge, and this decides whether the start is kept or discarded. Reaching it needs a run of single-beat frames on consecutive clocks, longer than the queue depth plus the release rate allows. The stimulus drives such bursts directly, and random traffic with high valid and ready rates also hits it with the release landing on varying phases. A cycle-level reference model in the bench decides for each start whether it is kept or dropped, and that decision is compared against the outputs.

// File: rtl/ptp_tx_stamp_pkg.sv
package ptp_tx_stamp_pkg;

    localparam int STAMP_W = 96;
    localparam int TAG_W   = 16;
    localparam int USER_W  = TAG_W + 1;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic [TAG_W-1:0]   tag;
    } stamp_rec_t;

    // tuser bit 0 is the error mark; the tag occupies the bits above it
    function automatic logic [TAG_W-1:0] tag_from_user(input logic [USER_W-1:0] user);
        return user[USER_W-1:1];
    endfunction

endpackage

// File: rtl/ptp_tx_sof_track.sv
module ptp_tx_sof_track (
    input  logic clk,
    input  logic rst,
    input  logic beat_valid,
    input  logic beat_ready,
    input  logic beat_last,
    output logic sof_fire
);
    logic frame_open;
    logic beat_take;

    assign beat_take = beat_valid & beat_ready;
    assign sof_fire  = beat_take & ~frame_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open <= 1'b0;
        end else if (beat_take) begin
            frame_open <= ~beat_last;
        end
    end
endmodule

// File: rtl/ptp_tx_stamp_fifo.sv
module ptp_tx_stamp_fifo
    import ptp_tx_stamp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  stamp_rec_t    push_rec,
    input  logic          pop,
    output stamp_rec_t    head_rec,
    output logic [CW-1:0] fill
);
    stamp_rec_t    slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_rec = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ptp_tx_report_pacer.sv
module ptp_tx_report_pacer
    import ptp_tx_stamp_pkg::*;
#(
    parameter int OUT_GAP = 3,
    localparam int GW = $clog2(OUT_GAP + 2)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       have_entry,
    input  stamp_rec_t head_rec,
    output logic       pop,
    output stamp_rec_t out_rec,
    output logic       out_valid
);
    logic [GW-1:0] hold_cnt;

    assign pop = have_entry && (hold_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt  <= '0;
            out_rec   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= pop;
            if (pop) begin
                out_rec  <= head_rec;
                hold_cnt <= GW'(OUT_GAP);
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptp_tx_stamp.sv
module ptp_tx_stamp
    import ptp_tx_stamp_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int OUT_GAP = 3,
    parameter bit TIME_EN = 1'b1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fr_valid,
    input  logic               fr_ready,
    input  logic               fr_last,
    input  logic [USER_W-1:0]  fr_user,
    input  logic [STAMP_W-1:0] ptp_now,
    output logic [STAMP_W-1:0] res_stamp,
    output logic [TAG_W-1:0]   res_tag,
    output logic               res_valid,
    output logic               stamp_overflow
);
    logic          sof;
    logic          q_pop;
    logic          q_push;
    logic [CW-1:0] q_fill;
    stamp_rec_t    cap_rec;
    stamp_rec_t    head_rec;
    stamp_rec_t    out_rec;
    logic [STAMP_W-1:0] time_seen;

    generate
        if (TIME_EN) begin : g_time
            assign time_seen = ptp_now;
        end else begin : g_no_time
            assign time_seen = '0;
        end
    endgenerate

    ptp_tx_sof_track u_sof (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (fr_valid),
        .beat_ready (fr_ready),
        .beat_last  (fr_last),
        .sof_fire   (sof)
    );

    always_comb begin
        cap_rec.stamp = time_seen;
        cap_rec.tag   = tag_from_user(fr_user);
    end

    // a full queue still accepts when the pacer frees a slot on the same edge
    assign q_push = sof && ((q_fill < CW'(DEPTH)) || q_pop);

    ptp_tx_stamp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_rec (cap_rec),
        .pop      (q_pop),
        .head_rec (head_rec),
        .fill     (q_fill)
    );

    ptp_tx_report_pacer #(.OUT_GAP(OUT_GAP)) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .have_entry (q_fill != '0),
        .head_rec   (head_rec),
        .pop        (q_pop),
        .out_rec    (out_rec),
        .out_valid  (res_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_overflow <= 1'b0;
        end else if (sof && !q_push) begin
            stamp_overflow <= 1'b1;
        end
    end

    assign res_stamp = out_rec.stamp;
    assign res_tag   = out_rec.tag;
endmodule

// File: rtl/ptp_tx_stamp_chk.sv
module ptp_tx_stamp_chk #(
    parameter int DEPTH   = 4,
    parameter int OUT_GAP = 3,
    parameter bit TIME_EN = 1'b1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          res_valid,
    input logic [95:0]   res_stamp,
    input logic          stamp_overflow,
    input logic [CW-1:0] fill
);
    // R6: a report strobe never lasts two clocks
    generate
        if (OUT_GAP > 0) begin : g_gap
            a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
                res_valid |=> !res_valid);
        end
        if (!TIME_EN) begin : g_zero
            // R9
            a_r9_stamp_zero: assert property (@(posedge clk) disable iff (rst)
                res_valid |-> (res_stamp == '0));
        end
    endgenerate

    // R7: an empty queue cannot produce a strobe on the next edge
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |=> !res_valid);

    // R5: occupancy bound
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R8: overflow is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        stamp_overflow |=> stamp_overflow);
endmodule

bind ptp_tx_stamp ptp_tx_stamp_chk #(
    .DEPTH   (DEPTH),
    .OUT_GAP (OUT_GAP),
    .TIME_EN (TIME_EN)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .res_valid      (res_valid),
    .res_stamp      (res_stamp),
    .stamp_overflow (stamp_overflow),
    .fill           (q_fill)
);

// File: tb/ptp_tx_stamp_tb.sv
module ptp_tx_stamp_tb;
    localparam int DEPTH = 4;
    localparam int GAP   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        fr_valid, fr_ready, fr_last;
    logic [16:0] fr_user;
    logic [95:0] ptp_now;
    logic [95:0] res_stamp, nt_stamp;
    logic [15:0] res_tag, nt_tag;
    logic        res_valid, nt_valid;
    logic        ovf, nt_ovf;

    ptp_tx_stamp #(.DEPTH(DEPTH), .OUT_GAP(GAP), .TIME_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .fr_valid(fr_valid), .fr_ready(fr_ready),
        .fr_last(fr_last), .fr_user(fr_user), .ptp_now(ptp_now),
        .res_stamp(res_stamp), .res_tag(res_tag), .res_valid(res_valid),
        .stamp_overflow(ovf));

    ptp_tx_stamp #(.DEPTH(DEPTH), .OUT_GAP(GAP), .TIME_EN(1'b0)) u_dut_nt (
        .clk(clk), .rst(rst), .fr_valid(fr_valid), .fr_ready(fr_ready),
        .fr_last(fr_last), .fr_user(fr_user), .ptp_now(ptp_now),
        .res_stamp(nt_stamp), .res_tag(nt_tag), .res_valid(nt_valid),
        .stamp_overflow(nt_ovf));

    int checks = 0;
    int errors = 0;
    logic [63:0] tick = '0;

    // reference model state
    logic [95:0] mq_t[$];
    logic [15:0] mq_g[$];
    int          mhold;
    bit          mopen, movf, ev;
    logic [95:0] ets;
    logic [15:0] etag;

    task automatic chk(input string req, input logic [111:0] act, input logic [111:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mq_t.delete(); mq_g.delete();
        mhold = 0; mopen = 0; movf = 0; ev = 0; ets = '0; etag = '0;
    endtask

    function automatic logic [15:0] exp_tag(input logic [16:0] u);
        return u[16:1];
    endfunction

    task automatic model_step();
        bit pop, sof;
        pop = (mq_t.size() > 0) && (mhold == 0);
        if (pop) begin
            ev = 1; ets = mq_t.pop_front(); etag = mq_g.pop_front(); mhold = GAP;
        end else begin
            ev = 0;
            if (mhold > 0) mhold--;
        end
        sof = fr_valid && fr_ready && !mopen;
        if (sof) begin
            if (mq_t.size() < DEPTH) begin
                mq_t.push_back(ptp_now); mq_g.push_back(exp_tag(fr_user));
            end else begin
                movf = 1;
            end
        end
        if (fr_valid && fr_ready) mopen = !fr_last;
    endtask

    task automatic compare();
        chk("R6 R7 R10 valid", 112'(res_valid), 112'(ev));
        chk("R9 valid without time", 112'(nt_valid), 112'(ev));
        if (ev) begin
            chk("R2 R4 R5 stamp", 112'(res_stamp), 112'(ets));
            chk("R3 R5 tag", 112'(res_tag), 112'(etag));
            chk("R9 stamp zero", 112'(nt_stamp), 112'(0));
            chk("R9 tag without time", 112'(nt_tag), 112'(etag));
        end
        chk("R8 overflow", 112'(ovf), 112'(movf));
    endtask

    // drive at negedge, step model, cross posedge, check at next negedge
    task automatic beat(input bit v, input bit r, input bit l, input logic [16:0] u);
        fr_valid = v; fr_ready = r; fr_last = l; fr_user = u;
        ptp_now = {32'hC0DE_5A00, tick};
        model_step();
        @(posedge clk);
        @(negedge clk);
        tick++;
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1; fr_valid = 0; fr_ready = 0; fr_last = 0; fr_user = '0;
        repeat (3) begin
            @(negedge clk);
            tick++;
            ptp_now = {32'hC0DE_5A00, tick};
        end
        chk("R1 reset stamp", 112'(res_stamp), 112'(0));
        chk("R1 reset tag", 112'(res_tag), 112'(0));
        chk("R1 reset valid", 112'(res_valid), 112'(0));
        chk("R1 reset overflow", 112'(ovf), 112'(0));
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();

        // R10 R3: single-beat frame into an idle unit, error bit set
        beat(1, 1, 1, {16'hBEEF, 1'b1});
        beat(0, 0, 0, '0);
        beat(0, 0, 0, '0);
        repeat (4) beat(0, 1, 0, '0);

        // R4: multi-beat frame with stalls; later beats carry other tuser values
        beat(1, 0, 0, {16'h1111, 1'b0});   // no handshake, no capture
        beat(1, 1, 0, {16'h2222, 1'b0});   // first accepted beat
        beat(1, 0, 0, {16'h3333, 1'b1});
        beat(1, 1, 0, {16'h4444, 1'b1});
        beat(0, 1, 1, {16'h5555, 1'b0});
        beat(1, 1, 1, {16'h6666, 1'b0});   // closes frame
        repeat (6) beat(0, 0, 0, '0);

        // R5 R8: burst of one-beat frames on every clock overruns the queue
        for (int i = 0; i < 14; i++) beat(1, 1, 1, {16'(16'hA000 + i), i[0]});
        repeat (30) beat(0, 0, 0, '0);
        chk("R8 overflow held", 112'(ovf), 112'(1));

        // R1 again, then random traffic
        @(negedge clk);
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            beat(($urandom % 10) < 7, ($urandom % 10) < 7, ($urandom % 10) < 4,
                 17'($urandom));
        end
        repeat (30) beat(0, 0, 0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule